// File: doc/BRIEF.md
# Flash Erase Status and Timing Engine

This block produces the embedded-operation status byte of a parallel NOR flash that follows the common unlock/command style of command set, and it times the operations that the byte reports on. A separate command decoder turns bus writes into single-cycle strobes: program start (with the most significant data bit being written), sector erase start, chip erase start, erase suspend, erase resume and status read. The engine answers with the status byte and a one-cycle completion pulse. The flash array itself is held elsewhere.

One down-counter serves every timed phase. These are the program duration, the acceptance window in which further sector erases may be queued, the sector erase itself, and the chip erase. The sector erase lasts one fixed unit per queued sector, so a burst of sector commands inside the window lengthens the erase. A suspend parks the count in a save register. A later resume reloads the count and goes straight into the erase phase.

All times are counted in clock cycles. A parameter sets the number of cycles per microsecond, so the same block runs in real or scaled time.

Top module: `erase_status_engine`

## Requirements
- R1: A synchronous reset clears the status byte to 0x00, stops the timer, empties the queued-sector count and the saved time, and holds the completion pulse low.
- R2: A status-read strobe in the cycle it is given toggles bit 6 during a program and toggles both bit 6 and bit 2 during a sector or chip erase; with no operation and no suspended erase it changes nothing.
- R3: A program start while no operation runs sets bit 7 to the inverse of the supplied data bit 7; the program completes PROG_US*CYC_PER_US cycles after its start edge, with a one-cycle completion pulse and bit 7 toggled.
- R4: A chip erase start (only when idle and no erase is suspended) forces bit 7 to 0 and completes (1<<CHIP_EXP)*1000*CYC_PER_US cycles after its start edge, with the completion pulse and bit 7 toggled.
- R5: A sector erase start forces bit 7 to 0 and opens (or restarts) an acceptance window of WINDOW_US*CYC_PER_US cycles with bit 3 at 0; each accepted start adds one queued sector; when the window expires, bit 3 becomes 1.
- R6: The erase phase lasts (1<<SECTOR_EXP)*CYC_PER_US cycles per queued sector; at its end bit 3 returns to 0, bit 7 toggles, the completion pulse fires once and the queued count is cleared.
- R7: A suspend during the acceptance window saves the full erase time of the queued sectors, stops the timer and leaves bit 3 at 0; no completion happens while suspended.
- R8: A suspend during the erase phase saves the timer count of that cycle, at least 1, and clears bit 3; a suspend in the very cycle of expiry wins over the expiry; a resume then sets bit 7 to 0 and bit 3 to 1 and completes the saved number of cycles after its edge.
- R9: While an erase is suspended, a status read flagged as hitting an erasing sector toggles only bit 2; an unflagged read changes nothing.
- R10: Strobes that do not apply are ignored with no effect on status or completion time: a sector start during the erase phase or a chip erase, a chip start while busy, and a resume with nothing suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| progStart | input | 1 | Program operation start strobe |
| progDataMsb | input | 1 | Bit 7 of the data being programmed, valid with progStart |
| sectStart | input | 1 | Sector erase command strobe |
| chipStart | input | 1 | Chip erase command strobe |
| suspendReq | input | 1 | Erase suspend strobe |
| resumeReq | input | 1 | Erase resume strobe |
| statusRead | input | 1 | Status read strobe |
| readHitsErasing | input | 1 | The status read addresses a sector that is being erased |
| statusByte | output | 8 | Status byte: bit 7 polarity, bit 6 toggle, bit 3 erase started, bit 2 erase toggle |
| opDone | output | 1 | One-cycle pulse when an operation completes |

## Verification
The bench aims at the queuing window. A second sector command must restart the window, so a design that keeps the first deadline raises bit 3 early. The erase length must scale with the queue and the queue must be emptied after each erase; a design that fails either way completes at the wrong cycle, and the scoreboard reports that cycle. Suspend is tried in the window, mid-erase and in the exact cycle of expiry. A design that saves the wrong count, lets the expiry win or forgets the floor of one completes early, late or never. Status reads while suspended check that bit 6 stays still while bit 2 toggles only for reads that hit an erasing sector, and stray strobes during busy phases must not move the completion cycle.

// File: rtl/esg_pkg.sv
package esg_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } opKind_e;

  // Strobes from control to the status datapath
  typedef struct packed {
    logic loadDq7;
    logic loadVal;
    logic clrDq7;
    logic togDq7;
    logic togDq6;
    logic togDq2;
    logic setDq3;
    logic clrDq3;
  } statCtl_t;

endpackage

// File: rtl/esg_ctrl.sv
module esg_ctrl
  import esg_pkg::*;
#(
  parameter int CYC_PER_US = 1,
  parameter int WINDOW_US  = 50,
  parameter int PROG_US    = 8,
  parameter int SECTOR_EXP = 9,
  parameter int CHIP_EXP   = 12,
  parameter int QUEUE_W    = 8,
  parameter int TIMER_W    = 40
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     progStart,
  input  logic     progDataMsb,
  input  logic     sectStart,
  input  logic     chipStart,
  input  logic     suspendReq,
  input  logic     resumeReq,
  input  logic     statusRead,
  input  logic     readHitsErasing,
  output statCtl_t ctl,
  output logic     opDone,
  output logic     busy,
  output logic     held
);

  localparam logic [TIMER_W-1:0] ONE       = TIMER_W'(1);
  localparam logic [TIMER_W-1:0] WIN_CYC   = TIMER_W'(64'(WINDOW_US) * 64'(CYC_PER_US));
  localparam logic [TIMER_W-1:0] PROG_CYC  = TIMER_W'(64'(PROG_US) * 64'(CYC_PER_US));
  localparam logic [TIMER_W-1:0] SECT_UNIT = TIMER_W'((64'd1 << SECTOR_EXP) * 64'(CYC_PER_US));
  localparam logic [TIMER_W-1:0] CHIP_CYC  = TIMER_W'((64'd1 << CHIP_EXP) * 64'd1000 * 64'(CYC_PER_US));
  localparam logic [QUEUE_W-1:0] QUEUE_MAX = '1;

  opKind_e            op, opNext;
  logic [TIMER_W-1:0] timer, timerNext;
  logic [TIMER_W-1:0] saved, savedNext;
  logic [QUEUE_W-1:0] queue, queueNext;
  logic               erasing, erasingNext;
  logic               doneNext;
  logic [TIMER_W-1:0] eraseTime;
  logic               idleFree, takeSusp, takeRes, takeSect, takeChip, takeProg, expire;

  assign busy = (op != OP_IDLE);
  assign held = (saved != '0);

  always_comb begin
    opNext      = op;
    timerNext   = timer;
    savedNext   = saved;
    queueNext   = queue;
    erasingNext = erasing;
    doneNext    = 1'b0;
    ctl         = '0;

    eraseTime = SECT_UNIT * TIMER_W'(queue);
    idleFree  = (op == OP_IDLE) && !held;
    takeSusp  = suspendReq && (op == OP_SECT);
    takeRes   = resumeReq && (op == OP_IDLE) && held;
    takeSect  = sectStart && (idleFree || ((op == OP_SECT) && !erasing));
    takeChip  = chipStart && idleFree;
    takeProg  = progStart && (op == OP_IDLE);
    expire    = busy && (timer == ONE);

    if (takeSusp) begin
      savedNext   = erasing ? ((timer > ONE) ? timer : ONE) : eraseTime;
      timerNext   = '0;
      erasingNext = 1'b0;
      opNext      = OP_IDLE;
      ctl.clrDq3  = 1'b1;
    end else if (takeRes) begin
      timerNext   = saved;
      savedNext   = '0;
      erasingNext = 1'b1;
      opNext      = OP_SECT;
      ctl.clrDq7  = 1'b1;
      ctl.setDq3  = 1'b1;
    end else if (takeSect) begin
      queueNext  = (queue == QUEUE_MAX) ? queue : queue + 1'b1;
      timerNext  = WIN_CYC;
      opNext     = OP_SECT;
      ctl.clrDq7 = 1'b1;
    end else if (takeChip) begin
      timerNext  = CHIP_CYC;
      opNext     = OP_CHIP;
      ctl.clrDq7 = 1'b1;
    end else if (takeProg) begin
      timerNext   = PROG_CYC;
      opNext      = OP_PROG;
      ctl.loadDq7 = 1'b1;
      ctl.loadVal = ~progDataMsb;
    end else if (expire) begin
      if ((op == OP_SECT) && !erasing) begin
        erasingNext = 1'b1;
        timerNext   = eraseTime;
        ctl.setDq3  = 1'b1;
      end else begin
        timerNext  = '0;
        opNext     = OP_IDLE;
        doneNext   = 1'b1;
        ctl.togDq7 = 1'b1;
        if (op == OP_SECT) begin
          queueNext   = '0;
          erasingNext = 1'b0;
          ctl.clrDq3  = 1'b1;
        end
      end
    end else if (busy) begin
      timerNext = timer - ONE;
    end

    if (statusRead) begin
      unique case (op)
        OP_PROG: ctl.togDq6 = 1'b1;
        OP_SECT, OP_CHIP: begin
          ctl.togDq6 = 1'b1;
          ctl.togDq2 = 1'b1;
        end
        default: ctl.togDq2 = held && readHitsErasing;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op      <= OP_IDLE;
      timer   <= '0;
      saved   <= '0;
      queue   <= '0;
      erasing <= 1'b0;
      opDone  <= 1'b0;
    end else begin
      op      <= opNext;
      timer   <= timerNext;
      saved   <= savedNext;
      queue   <= queueNext;
      erasing <= erasingNext;
      opDone  <= doneNext;
    end
  end

endmodule

// File: rtl/esg_status.sv
module esg_status
  import esg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  statCtl_t   ctl,
  output logic [7:0] statusByte
);

  logic dq7, dq6, dq3, dq2;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq7 <= 1'b0;
      dq6 <= 1'b0;
      dq3 <= 1'b0;
      dq2 <= 1'b0;
    end else begin
      if (ctl.loadDq7)     dq7 <= ctl.loadVal;
      else if (ctl.clrDq7) dq7 <= 1'b0;
      else if (ctl.togDq7) dq7 <= ~dq7;
      if (ctl.togDq6) dq6 <= ~dq6;
      if (ctl.setDq3)      dq3 <= 1'b1;
      else if (ctl.clrDq3) dq3 <= 1'b0;
      if (ctl.togDq2) dq2 <= ~dq2;
    end
  end

  assign statusByte = {dq7, dq6, 2'b00, dq3, dq2, 2'b00};

endmodule

// File: rtl/erase_status_engine.sv
module erase_status_engine
  import esg_pkg::*;
#(
  parameter int CYC_PER_US = 1,
  parameter int WINDOW_US  = 50,
  parameter int PROG_US    = 8,
  parameter int SECTOR_EXP = 9,
  parameter int CHIP_EXP   = 12,
  parameter int QUEUE_W    = 8,
  parameter int TIMER_W    = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       progStart,
  input  logic       progDataMsb,
  input  logic       sectStart,
  input  logic       chipStart,
  input  logic       suspendReq,
  input  logic       resumeReq,
  input  logic       statusRead,
  input  logic       readHitsErasing,
  output logic [7:0] statusByte,
  output logic       opDone
);

  statCtl_t ctlBus;
  logic     ctlBusy;
  logic     ctlHeld;

  esg_ctrl #(
    .CYC_PER_US(CYC_PER_US), .WINDOW_US(WINDOW_US), .PROG_US(PROG_US),
    .SECTOR_EXP(SECTOR_EXP), .CHIP_EXP(CHIP_EXP), .QUEUE_W(QUEUE_W), .TIMER_W(TIMER_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .progStart(progStart), .progDataMsb(progDataMsb),
    .sectStart(sectStart), .chipStart(chipStart),
    .suspendReq(suspendReq), .resumeReq(resumeReq),
    .statusRead(statusRead), .readHitsErasing(readHitsErasing),
    .ctl(ctlBus), .opDone(opDone), .busy(ctlBusy), .held(ctlHeld)
  );

  esg_status u_status (
    .clk(clk), .rst(rst), .ctl(ctlBus), .statusByte(statusByte)
  );

endmodule

// File: rtl/esg_checker.sv
module esg_checker (
  input logic       clk,
  input logic       rst,
  input logic       progStart,
  input logic       progDataMsb,
  input logic       sectStart,
  input logic       chipStart,
  input logic       suspendReq,
  input logic       resumeReq,
  input logic [7:0] statusByte,
  input logic       opDone,
  input logic       busy,
  input logic       held
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (statusByte == 8'h00) && !opDone);

  p_dq6_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> $stable(statusByte[6]));

  p_prog_inverse_r3: assert property (@(posedge clk) disable iff (rst)
    (progStart && !busy && !sectStart && !chipStart && !suspendReq && !resumeReq)
      |=> (statusByte[7] == !$past(progDataMsb)));

  p_single_done_r6: assert property (@(posedge clk) disable iff (rst)
    opDone |=> !opDone);

  p_done_flips_dq7_r6: assert property (@(posedge clk) disable iff (rst)
    opDone |-> (statusByte[7] != $past(statusByte[7])));

  p_held_dq3_low_r7: assert property (@(posedge clk) disable iff (rst)
    held |-> !statusByte[3]);

  p_resume_sets_dq3_r8: assert property (@(posedge clk) disable iff (rst)
    (resumeReq && held && !busy && !suspendReq) |=> (statusByte[3] && !statusByte[7]));

endmodule

bind erase_status_engine esg_checker i_chk (
  .clk(clk), .rst(rst),
  .progStart(progStart), .progDataMsb(progDataMsb),
  .sectStart(sectStart), .chipStart(chipStart),
  .suspendReq(suspendReq), .resumeReq(resumeReq),
  .statusByte(statusByte), .opDone(opDone),
  .busy(ctlBusy), .held(ctlHeld)
);

// File: tb/test_erase_status_engine.sv
module test_erase_status_engine;

  localparam int WIN  = 20;
  localparam int PROG = 6;
  localparam int UNIT = 8;
  localparam int CHIP = 2000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       progStart = 1'b0, progDataMsb = 1'b0;
  logic       sectStart = 1'b0, chipStart = 1'b0;
  logic       suspendReq = 1'b0, resumeReq = 1'b0;
  logic       statusRead = 1'b0, readHitsErasing = 1'b0;
  logic [7:0] statusByte;
  logic       opDone;

  int cyc = 0;
  int lastEdge = 0;
  int checks = 0;
  int errors = 0;
  int expDone[$];
  bit finished = 0;

  erase_status_engine #(
    .CYC_PER_US(1), .WINDOW_US(WIN), .PROG_US(PROG),
    .SECTOR_EXP(3), .CHIP_EXP(1), .QUEUE_W(8), .TIMER_W(40)
  ) i_erase_status_engine (
    .clk(clk), .rst(rst),
    .progStart(progStart), .progDataMsb(progDataMsb),
    .sectStart(sectStart), .chipStart(chipStart),
    .suspendReq(suspendReq), .resumeReq(resumeReq),
    .statusRead(statusRead), .readHitsErasing(readHitsErasing),
    .statusByte(statusByte), .opDone(opDone)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: every completion pulse must match the next expected cycle
  always @(negedge clk) begin
    if (!rst && opDone) begin
      checks++;
      if (expDone.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected completion at cycle %0d (expected none)", cyc);
      end else begin
        int e;
        e = expDone.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R6 completion at cycle %0d, expected %0d", cyc, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (!finished && cyc == 60000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d, expected end before 60000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s status 0x%02h expected 0x%02h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // All stimulus tasks are entered at a negedge; lastEdge is the action edge
  task automatic doProg(input logic b);
    progDataMsb = b; progStart = 1'b1;
    @(negedge clk); progStart = 1'b0; lastEdge = cyc;
  endtask
  task automatic doSect();
    sectStart = 1'b1; @(negedge clk); sectStart = 1'b0; lastEdge = cyc;
  endtask
  task automatic doChip();
    chipStart = 1'b1; @(negedge clk); chipStart = 1'b0; lastEdge = cyc;
  endtask
  task automatic doSuspend();
    suspendReq = 1'b1; @(negedge clk); suspendReq = 1'b0; lastEdge = cyc;
  endtask
  task automatic doResume();
    resumeReq = 1'b1; @(negedge clk); resumeReq = 1'b0; lastEdge = cyc;
  endtask
  task automatic doRead(input logic hit);
    readHitsErasing = hit; statusRead = 1'b1;
    @(negedge clk); statusRead = 1'b0; readHitsErasing = 1'b0; lastEdge = cyc;
  endtask
  task automatic waitUntil(input int target);
    while (cyc < target) @(negedge clk);
  endtask
  task automatic expectDone(input int at);
    expDone.push_back(at);
  endtask

  initial begin
    int endAt, s2, e, r, saveLen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset", statusByte, 8'h00);
    checks++;
    if (opDone !== 1'b0) begin
      errors++;
      $display("FAIL R1 done %0b expected 0", opDone);
    end

    doRead(1'b0);
    chk("R2 idle read", statusByte, 8'h00);

    // Program with data bit 7 = 0
    doProg(1'b0); endAt = lastEdge + PROG; expectDone(endAt);
    chk("R3 prog inverse", statusByte, 8'h80);
    doRead(1'b0);
    chk("R2 prog read dq6 only", statusByte, 8'hC0);
    doRead(1'b0);
    waitUntil(endAt);
    chk("R3 prog end toggles dq7", statusByte, 8'h00);

    doProg(1'b1); endAt = lastEdge + PROG; expectDone(endAt);
    chk("R3 prog inverse one", statusByte, 8'h00);
    waitUntil(endAt);
    chk("R3 prog end", statusByte, 8'h80);

    // Chip erase with an ignored sector start
    doChip(); endAt = lastEdge + CHIP; expectDone(endAt);
    chk("R4 chip dq7 low", statusByte, 8'h00);
    doRead(1'b0);
    chk("R2 erase read dq6 dq2", statusByte, 8'h44);
    doSect();
    doChip();
    waitUntil(endAt);
    chk("R4 R10 chip end", statusByte, 8'hC4);
    doRead(1'b0);
    chk("R2 idle read after", statusByte, 8'hC4);

    // Two queued sectors, window restart
    doSect();
    chk("R5 sector dq7 low", statusByte, 8'h44);
    waitUntil(lastEdge + 4);
    doSect(); s2 = lastEdge;
    expectDone(s2 + WIN + 2 * UNIT);
    waitUntil(s2 + WIN - 1);
    chk("R5 window still open", statusByte, 8'h44);
    waitUntil(s2 + WIN);
    chk("R5 window expired dq3", statusByte, 8'h4C);
    doSect();
    waitUntil(s2 + WIN + 2 * UNIT);
    chk("R6 sector end", statusByte, 8'hC4);

    // Queue cleared: single sector timing
    doSect(); e = lastEdge; expectDone(e + WIN + UNIT);
    waitUntil(e + WIN + UNIT);
    chk("R6 queue cleared end", statusByte, 8'hC4);

    // Suspend in the window saves full time
    doSect(); e = lastEdge;
    waitUntil(e + 9);
    doSuspend();
    chk("R7 suspend in window", statusByte, 8'h44);
    repeat (50) @(negedge clk);
    chk("R7 suspended holds", statusByte, 8'h44);
    doRead(1'b1);
    chk("R9 hit read dq2 only", statusByte, 8'h40);
    doRead(1'b0);
    chk("R9 miss read none", statusByte, 8'h40);
    doChip();
    chk("R10 chip while held", statusByte, 8'h40);
    doResume(); r = lastEdge; expectDone(r + UNIT);
    chk("R8 resume dq3 set", statusByte, 8'h48);
    waitUntil(r + UNIT);
    chk("R7 full time after resume", statusByte, 8'hC0);

    // Suspend in the erase phase saves the remaining count
    doSect(); e = lastEdge;
    waitUntil(e + WIN + 2);
    doSuspend();
    saveLen = (e + WIN + UNIT) - lastEdge + 1;
    chk("R8 suspend clears dq3", statusByte, 8'h40);
    repeat (30) @(negedge clk);
    doResume(); r = lastEdge; expectDone(r + saveLen);
    waitUntil(r + saveLen);
    chk("R8 remaining time", statusByte, 8'hC0);

    // Suspend on the expiry edge saves a count of one
    doSect(); e = lastEdge;
    waitUntil(e + WIN + UNIT - 1);
    doSuspend();
    chk("R8 suspend beats expiry", statusByte, 8'h40);
    repeat (10) @(negedge clk);
    doResume(); r = lastEdge; expectDone(r + 1);
    waitUntil(r + 1);
    chk("R8 floor of one", statusByte, 8'hC0);

    // Resume with nothing saved
    doResume();
    chk("R10 stray resume", statusByte, 8'hC0);
    repeat (30) @(negedge clk);
    chk("R10 still idle", statusByte, 8'hC0);

    checks++;
    if (expDone.size() != 0) begin
      errors++;
      $display("FAIL R6 %0d completions missing, expected 0", expDone.size());
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule